// File: doc/BRIEF.md
# Branch target buffer fetch unit

This block sits in the fetch stage and turns the current program counter into the address to fetch on the following cycle. It keeps a direct-mapped table of branch entries. Each entry holds a valid flag, an address tag, the last known branch target and a two-bit direction state. A single combinational lookup answers three questions in the same cycle as fetch: is this PC a known branch, is it predicted taken, and where does it go. The chosen address is then registered by the surrounding fetch logic and used one cycle later.

A resolve port, driven by a later pipeline stage once a branch has executed, trains the table. It carries the branch PC, the real direction and the real target. A branch that is already in the table has its entry trained. A taken branch that misses gets an entry, and that entry replaces whatever entry shared its index. A parameter selects the direction policy. One policy keeps a single last-outcome bit. The other keeps a two-bit saturating counter, so one unusual outcome does not flip the prediction.

Top module: `btb_fetch_unit`

## Requirements
- R1: A synchronous reset clears every valid flag. From the first cycle after reset, every lookup misses (`pred_hit`=0, `pred_taken`=0, `next_pc`=`fetch_pc`+4) until entries are trained.
- R2: A lookup selects its entry with `fetch_pc[IDX_W+1:2]`. It hits only if that entry is valid and its stored tag equals `fetch_pc[ADDR_W-1:IDX_W+2]`. A PC that shares an index but has a different tag misses.
- R3: `next_pc` is the stored target only when the lookup hits and the direction state's upper bit is 1 (`pred_taken`=1). In every other case it is `fetch_pc`+4. The result depends combinationally on `fetch_pc` in the same cycle.
- R4: A taken resolve that misses allocates the entry: valid=1, the tag of `res_pc`, target=`res_target`, direction state 2'b10 (predict taken). From the next cycle, a lookup of `res_pc` hits and predicts taken to that target.
- R5: A not-taken resolve that misses writes nothing, so later lookups of that PC still miss.
- R6: With the last-outcome policy (`DIR_MODE`=DIR_LAST), a resolve that hits overwrites the direction with the actual outcome. A single not-taken outcome therefore turns the prediction to not taken.
- R7: With the counter policy (`DIR_MODE`=DIR_SAT2), a resolve that hits steps the 2-bit counter up on taken and down on not taken. Values 2 and 3 predict taken. From 3, one not-taken outcome still predicts taken and two flip the prediction.
- R8: A taken resolve that hits replaces the stored target with `res_target`. A not-taken resolve that hits leaves the target unchanged.
- R9: If a lookup and a resolve touch the same index in one cycle, the lookup sees the old contents. The update is visible from the next cycle.
- R10: A taken resolve that misses on an index held by a different tag evicts that entry. The old PC then misses.
- R11: The counter saturates: taken at 3 stays at 3, and not taken at 0 stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | ADDR_W | Address of the instruction being fetched |
| next_pc | output | ADDR_W | Address to fetch on the next cycle |
| pred_hit | output | 1 | Lookup found a valid entry with matching tag |
| pred_taken | output | 1 | Lookup hit and predicts taken |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The properties assume that at most one branch resolves per cycle, that all addresses are word aligned, and that inputs are known in every cycle after reset. The properties that look one cycle back also assume the table changes only through the resolve port. The stimulus drives only aligned PCs, changes inputs only at the falling edge, and keeps `res_valid` low while reset is high. It trains entries in both directions and aliases several indices, so that the hit, eviction and counter-limit cases all occur within these limits.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic {
        DIR_LAST = 1'b0,
        DIR_SAT2 = 1'b1
    } dir_mode_e;

    localparam int INSN_BYTES = 4;
    localparam int ALIGN_BITS = 2;

    // state written into a freshly allocated entry: predicts taken
    localparam logic [1:0] DIR_INIT = 2'b10;

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int WORD_W = 30,
    parameter int IDX_W  = 4,
    localparam int TAG_W = WORD_W - IDX_W
) (
    input  logic [WORD_W-1:0] word_addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    // word address excludes the alignment bits; low part indexes, rest tags
    assign idx = word_addr[IDX_W-1:0];
    assign tag = word_addr[WORD_W-1:IDX_W];
endmodule

// File: rtl/btb_table.sv
module btb_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    // fetch-side read
    input  logic [IDX_W-1:0]  fr_idx,
    output logic              fr_valid,
    output logic [TAG_W-1:0]  fr_tag,
    output logic [ADDR_W-1:0] fr_target,
    output logic [1:0]        fr_dir,
    // resolve-side read
    input  logic [IDX_W-1:0]  rr_idx,
    output logic              rr_valid,
    output logic [TAG_W-1:0]  rr_tag,
    output logic [ADDR_W-1:0] rr_target,
    output logic [1:0]        rr_dir,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  logic [1:0]        wr_dir
);
    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][ADDR_W-1:0] target;
        logic [DEPTH-1:0][1:0]        dir;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.valid[wr_idx]  = 1'b1;
            tbl_d.tag[wr_idx]    = wr_tag;
            tbl_d.target[wr_idx] = wr_target;
            tbl_d.dir[wr_idx]    = wr_dir;
        end
        if (rst) begin
            tbl_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        tbl_q <= tbl_d;
    end

    // reads come from the registered state: same-cycle writes are not seen
    assign fr_valid  = tbl_q.valid[fr_idx];
    assign fr_tag    = tbl_q.tag[fr_idx];
    assign fr_target = tbl_q.target[fr_idx];
    assign fr_dir    = tbl_q.dir[fr_idx];

    assign rr_valid  = tbl_q.valid[rr_idx];
    assign rr_tag    = tbl_q.tag[rr_idx];
    assign rr_target = tbl_q.target[rr_idx];
    assign rr_dir    = tbl_q.dir[rr_idx];
endmodule

// File: rtl/btb_dir_update.sv
module btb_dir_update #(
    parameter btb_pkg::dir_mode_e MODE = btb_pkg::DIR_SAT2
) (
    input  logic [1:0] cur_dir,
    input  logic       taken,
    output logic [1:0] trained_dir,
    output logic [1:0] alloc_dir
);
    assign alloc_dir = btb_pkg::DIR_INIT;

    generate
        if (MODE == btb_pkg::DIR_SAT2) begin : g_sat
            always_comb begin
                trained_dir = cur_dir;
                if (taken && (cur_dir != 2'b11)) begin
                    trained_dir = cur_dir + 2'd1;
                end else if (!taken && (cur_dir != 2'b00)) begin
                    trained_dir = cur_dir - 2'd1;
                end
            end
        end else begin : g_last
            logic [1:0] unused_cur;
            assign unused_cur  = cur_dir;
            assign trained_dir = {taken, 1'b0};
        end
    endgenerate
endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              hit,
    input  logic              dir_msb,
    input  logic [ADDR_W-1:0] target,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] seq_pc;

    assign seq_pc  = pc + ADDR_W'(btb_pkg::INSN_BYTES);
    assign taken   = hit & dir_msb;
    assign next_pc = taken ? target : seq_pc;
endmodule

// File: rtl/btb_fetch_unit.sv
module btb_fetch_unit #(
    parameter int                 ADDR_W   = 32,
    parameter int                 IDX_W    = 4,
    parameter btb_pkg::dir_mode_e DIR_MODE = btb_pkg::DIR_SAT2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target
);
    localparam int WORD_W = ADDR_W - btb_pkg::ALIGN_BITS;
    localparam int TAG_W  = WORD_W - IDX_W;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
        logic [1:0]        dir;
    } wr_t;

    logic [IDX_W-1:0]  f_idx, r_idx;
    logic [TAG_W-1:0]  f_tag, r_tag;
    logic              f_valid, r_valid;
    logic [TAG_W-1:0]  f_stag, r_stag;
    logic [ADDR_W-1:0] f_target, r_target;
    logic [1:0]        f_dir, r_dir;
    logic [1:0]        trained_dir, alloc_dir;
    logic              f_hit, r_hit;
    wr_t               wr_d;
    logic              unused_res_lsb;

    assign unused_res_lsb = ^res_pc[btb_pkg::ALIGN_BITS-1:0];

    btb_pc_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_fsplit (
        .word_addr (fetch_pc[ADDR_W-1:btb_pkg::ALIGN_BITS]),
        .idx       (f_idx),
        .tag       (f_tag)
    );

    btb_pc_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rsplit (
        .word_addr (res_pc[ADDR_W-1:btb_pkg::ALIGN_BITS]),
        .idx       (r_idx),
        .tag       (r_tag)
    );

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .fr_idx    (f_idx),
        .fr_valid  (f_valid),
        .fr_tag    (f_stag),
        .fr_target (f_target),
        .fr_dir    (f_dir),
        .rr_idx    (r_idx),
        .rr_valid  (r_valid),
        .rr_tag    (r_stag),
        .rr_target (r_target),
        .rr_dir    (r_dir),
        .wr_en     (wr_d.en),
        .wr_idx    (wr_d.idx),
        .wr_tag    (wr_d.tag),
        .wr_target (wr_d.target),
        .wr_dir    (wr_d.dir)
    );

    btb_dir_update #(.MODE(DIR_MODE)) u_dir (
        .cur_dir     (r_dir),
        .taken       (res_taken),
        .trained_dir (trained_dir),
        .alloc_dir   (alloc_dir)
    );

    assign f_hit = f_valid && (f_stag == f_tag);
    assign r_hit = r_valid && (r_stag == r_tag);

    // resolve-side write request: train on hit, allocate on taken miss
    always_comb begin
        wr_d.en     = 1'b0;
        wr_d.idx    = r_idx;
        wr_d.tag    = r_tag;
        wr_d.target = res_target;
        wr_d.dir    = alloc_dir;
        if (res_valid) begin
            if (r_hit) begin
                wr_d.en  = 1'b1;
                wr_d.dir = trained_dir;
                if (!res_taken) begin
                    wr_d.target = r_target;
                end
            end else if (res_taken) begin
                wr_d.en = 1'b1;
            end
        end
    end

    btb_next_pc #(.ADDR_W(ADDR_W)) u_npc (
        .pc      (fetch_pc),
        .hit     (f_hit),
        .dir_msb (f_dir[1]),
        .target  (f_target),
        .taken   (pred_taken),
        .next_pc (next_pc)
    );

    assign pred_hit = f_hit;
endmodule

// File: rtl/btb_fetch_checker.sv
module btb_fetch_checker #(
    parameter int                 ADDR_W = 32,
    parameter int                 IDX_W  = 4,
    parameter btb_pkg::dir_mode_e MODE   = btb_pkg::DIR_SAT2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target
);
    localparam int UNUSED_IDX = IDX_W;

    assert_cold_miss_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_hit);

    assert_seq_fallthrough_R3: assert property (@(posedge clk) disable iff (rst)
        !(pred_hit && pred_taken) |-> next_pc == fetch_pc + ADDR_W'(4));

    assert_train_visible_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(res_valid && res_taken) && fetch_pc == $past(res_pc))
        |-> (pred_hit && (!pred_taken || next_pc == $past(res_target))));

    // R9: the table only changes through a resolve, so idle cycles hold the lookup
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(res_valid) && $stable(fetch_pc))
        |-> ($stable(next_pc) && $stable(pred_hit) && $stable(pred_taken)));

    generate
        if (MODE == btb_pkg::DIR_LAST) begin : g_last
            assert_last_outcome_R6: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(res_valid) && fetch_pc == $past(res_pc) && pred_hit)
                |-> pred_taken == $past(res_taken));
        end
    endgenerate
endmodule

bind btb_fetch_unit btb_fetch_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .MODE   (DIR_MODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .next_pc    (next_pc),
    .pred_hit   (pred_hit),
    .pred_taken (pred_taken),
    .res_valid  (res_valid),
    .res_pc     (res_pc),
    .res_taken  (res_taken),
    .res_target (res_target)
);

// File: tb/sim_btb_fetch_unit.sv
`timescale 1ns/1ps
module sim_btb_fetch_unit;
    localparam int AW    = 32;
    localparam int IW    = 4;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_pc = '0;
    logic          res_valid = 1'b0;
    logic [AW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_target = '0;
    logic [AW-1:0] npc0, npc1;
    logic          hit0, hit1, tk0, tk1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;  // 50 MHz

    btb_fetch_unit #(.ADDR_W(AW), .IDX_W(IW), .DIR_MODE(btb_pkg::DIR_SAT2)) u0 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .next_pc(npc0),
        .pred_hit(hit0), .pred_taken(tk0), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target));

    btb_fetch_unit #(.ADDR_W(AW), .IDX_W(IW), .DIR_MODE(btb_pkg::DIR_LAST)) u1 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .next_pc(npc1),
        .pred_hit(hit1), .pred_taken(tk1), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target));

    // requirement model: index pc[5:2], tag pc[31:6]
    logic          m_v   [DEPTH];
    logic [25:0]   m_tag [DEPTH];
    logic [AW-1:0] m_tgt [DEPTH];
    logic [1:0]    m_sat [DEPTH];
    logic          m_lst [DEPTH];

    typedef struct {
        logic [AW-1:0] pc;
        logic          h0, t0, h1, t1;
        logic [AW-1:0] n0, n1;
        string         req;
    } exp_t;

    exp_t exp_q[$];

    function automatic exp_t model_expect(input logic [AW-1:0] pc, input string req);
        exp_t e;
        int   i = int'(pc[5:2]);
        logic h = m_v[i] && (m_tag[i] == pc[31:6]);
        e.pc  = pc;
        e.req = req;
        e.h0  = h;
        e.h1  = h;
        e.t0  = h && m_sat[i][1];
        e.t1  = h && m_lst[i];
        e.n0  = e.t0 ? m_tgt[i] : pc + 32'd4;
        e.n1  = e.t1 ? m_tgt[i] : pc + 32'd4;
        return e;
    endfunction

    task automatic model_resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tg);
        int   i = int'(pc[5:2]);
        logic h = m_v[i] && (m_tag[i] == pc[31:6]);
        if (h) begin
            if (tk) m_tgt[i] = tg;                          // R8
            m_lst[i] = tk;                                   // R6
            if (tk && m_sat[i] != 2'b11) m_sat[i] = m_sat[i] + 2'd1;      // R7, R11
            else if (!tk && m_sat[i] != 2'b00) m_sat[i] = m_sat[i] - 2'd1;
        end else if (tk) begin                               // R4, R10
            m_v[i]   = 1'b1;
            m_tag[i] = pc[31:6];
            m_tgt[i] = tg;
            m_sat[i] = 2'b10;
            m_lst[i] = 1'b1;
        end
    endtask

    // driver: one cycle with an optional resolve, one expected lookup pushed
    task automatic step(input logic [AW-1:0] pc, input logic rv, input logic [AW-1:0] rpc,
                        input logic rtk, input logic [AW-1:0] rtg, input string req);
        @(negedge clk);
        fetch_pc   = pc;
        res_valid  = rv;
        res_pc     = rpc;
        res_taken  = rtk;
        res_target = rtg;
        exp_q.push_back(model_expect(pc, req));
        if (rv) model_resolve(rpc, rtk, rtg);
    endtask

    task automatic look(input logic [AW-1:0] pc, input string req);
        step(pc, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic train(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tg);
        step(pc, 1'b1, pc, tk, tg, "R9");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        res_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: pops expectations and compares in the middle of the low phase
    initial begin
        forever begin : mon
            exp_t e;
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                total++;
                if (hit0 !== e.h0 || tk0 !== e.t0 || npc0 !== e.n0) begin
                    bad++;
                    $display("FAIL %s counter pc=%h hit=%b/%b taken=%b/%b npc=%h/%h",
                             e.req, e.pc, hit0, e.h0, tk0, e.t0, npc0, e.n0);
                end
                total++;
                if (hit1 !== e.h1 || tk1 !== e.t1 || npc1 !== e.n1) begin
                    bad++;
                    $display("FAIL %s lastbit pc=%h hit=%b/%b taken=%b/%b npc=%h/%h",
                             e.req, e.pc, hit1, e.h1, tk1, e.t1, npc1, e.n1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [AW-1:0] PA = 32'h0000_0100;  // index 0
    localparam logic [AW-1:0] PB = 32'h0000_0140;  // index 0, other tag

    initial begin
        do_reset();
        // R1: cold table misses everywhere
        look(PA, "R1");
        look(32'h0000_1234 & ~32'h3, "R1");
        look(32'hFFFF_FFFC, "R1");

        // R5: not-taken miss writes nothing
        step(PA, 1'b1, PA, 1'b0, 32'h400, "R5");
        look(PA, "R5");

        // R9 then R4: same-cycle read sees old, next cycle sees allocation
        step(PA, 1'b1, PA, 1'b1, 32'h400, "R9");
        look(PA, "R4");
        // R2: alias with different tag misses
        look(PB, "R2");
        look(PA + 32'h4, "R2");

        // R6/R7: one not-taken from weakly taken
        train(PA, 1'b0, 32'h0);
        look(PA, "R6");
        // R7/R11: climb to strong and saturate
        train(PA, 1'b1, 32'h400);
        train(PA, 1'b1, 32'h400);
        train(PA, 1'b1, 32'h400);
        look(PA, "R11");
        // R7: one not-taken keeps counter predicting taken, last-bit flips
        train(PA, 1'b0, 32'h0);
        look(PA, "R7");
        train(PA, 1'b0, 32'h0);
        look(PA, "R7");
        train(PA, 1'b0, 32'h0);
        train(PA, 1'b0, 32'h0);
        look(PA, "R11");
        train(PA, 1'b1, 32'h500);
        look(PA, "R11");
        // R8: taken hit replaces target, not-taken keeps it
        train(PA, 1'b1, 32'h800);
        look(PA, "R8");
        train(PA, 1'b0, 32'hDEAD_0000);
        train(PA, 1'b1, 32'h800);
        look(PA, "R8");

        // R10: allocation on the same index evicts
        step(PB, 1'b1, PB, 1'b1, 32'h900, "R10");
        look(PB, "R10");
        look(PA, "R10");

        // R4/R3: fill the table with a mix of directions
        for (int i = 0; i < DEPTH; i++) begin
            step(32'h2000 + i * 4, 1'b1, 32'h3000 + i * 4, (i % 3) != 0,
                 32'h9000 + i * 16, "R4");
        end
        for (int i = 0; i < DEPTH; i++) begin
            look(32'h3000 + i * 4, "R3");
            look(32'h7000 + i * 4, "R2");
        end

        // R6/R7: alternating outcomes on one branch
        for (int i = 0; i < 8; i++) begin
            train(32'h3008, (i % 2) == 0, 32'hA000);
            look(32'h3008, "R7");
        end

        // R1: reset mid-run forgets everything
        do_reset();
        look(PB, "R1");
        look(32'h3004, "R1");
        look(32'h3008, "R1");

        repeat (2) @(negedge clk);
        #6;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule